// File: doc/BRIEF.md
# Programmable AND-Array Macrocell Block with Output Feedback

This block is a small array of sum-of-products cells. Each cell owns a fixed group of product terms whose AND inputs can be programmed, and those terms feed that cell's own OR gate, which cannot be programmed. A cell never borrows another cell's terms. A function that needs more terms than one cell has is split across cells: one cell's output is routed back into the AND array as an extra input, where another cell's term can pick it up.

Every cell also has a polarity bit that inverts its result. A single write port loads a cell's configuration in one clock. The write selects the cell by address and carries the cell's whole row of literal enables together with its polarity bit.

The block checks each write for a feedback cycle. If the write would make any cell depend on its own output, directly or through other cells, the row is not stored and an error flag is raised. The cell outputs are registered.

Top module: `pal_macro_array`

## Requirements
- R1: A synchronous active-high `rst` clears every stored row and polarity bit, drives `pal_out` to 0 and clears `config_error`.
- R2: When `wr_en` is high at a clock edge and the row causes no feedback cycle, `wr_data` is stored for cell `wr_addr`. The outputs registered at the next edge use the new row. Word layout: term t occupies bits [t*2*S +: 2*S], where S = N_IN + N_MC. Within a term, bit 2s enables the true form of signal s and bit 2s+1 enables its complement. Bit N_PT*2*S is the polarity bit.
- R3: A product term is the AND of its enabled literals. A term with no literal enabled contributes 0. A term that enables both forms of one signal is 0.
- R4: A cell's result is the OR of its own N_PT terms only. Polarity 1 inverts the result.
- R5: AND-array signal s is `din[s]` for s < N_IN. For higher s it is the unregistered result of cell s-N_IN. This lets one cell extend another cell's term count, through chains as long as N_MC cells.
- R6: `pal_out` is registered. The value visible after a clock edge is computed from the `din` and the configuration present before that edge.
- R7: A write that would create a feedback cycle leaves the stored row of that cell unchanged and sets `config_error` after the edge. The cycle may be a self-reference or pass through other cells.
- R8: An accepted write clears `config_error`. The flag holds its value while `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | $clog2(N_MC) | Cell selected by the write |
| wr_data | input | N_PT*2*(N_IN+N_MC)+1 | Row of literal enables plus polarity bit |
| din | input | N_IN | External inputs to the AND array |
| pal_out | output | N_MC | Registered cell results |
| config_error | output | 1 | Last write was rejected for a feedback cycle |

## Verification
The bench uses the defaults: four external inputs and four cells with three terms each. This is the smallest shape in which a four-variable function with four terms cannot fit in one cell and must use feedback. It also allows a dependency chain three cells deep, and loops of length one, two and three. A behavioural model resolves the cells in dependency order and checks cycles by transitive closure. It is compared with the outputs every clock. All 16 input combinations are also checked against the target Boolean expression.

// File: rtl/pal_array_pkg.sv
package pal_array_pkg;
  // Literal slot within a signal pair of an AND-term row
  localparam int LIT_TRUE = 0;
  localparam int LIT_COMP = 1;
  localparam int LIT_PAIR = 2;

  typedef enum logic {
    POL_HIGH = 1'b0,
    POL_LOW  = 1'b1
  } mc_pol_e;
endpackage

// File: rtl/pal_macrocell.sv
module pal_macrocell
  import pal_array_pkg::*;
#(
  parameter int N_SIG = 8,
  parameter int N_PT  = 3
) (
  input  logic [N_PT*LIT_PAIR*N_SIG-1:0] row,
  input  logic                           pol,
  input  logic [N_SIG-1:0]               sig,
  output logic                           mc_out
);
  localparam int TERM_W = LIT_PAIR * N_SIG;

  logic [TERM_W-1:0] lit_vec;
  logic [N_PT-1:0]   term_hit;

  always_comb begin
    for (int s = 0; s < N_SIG; s++) begin
      lit_vec[LIT_PAIR*s + LIT_TRUE] = sig[s];
      lit_vec[LIT_PAIR*s + LIT_COMP] = ~sig[s];
    end
  end

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    logic [TERM_W-1:0] trow;
    assign trow        = row[t*TERM_W +: TERM_W];
    assign term_hit[t] = (|trow) && (&(~trow | lit_vec));
  end

  assign mc_out = (|term_hit) ^ (mc_pol_e'(pol) == POL_LOW);

  // R3: with every term empty, the cell output equals its polarity
  always_comb begin
    if (row == '0) begin
      unused_term_chk: assert (mc_out == pol);
    end
  end
endmodule

// File: rtl/pal_loop_check.sv
module pal_loop_check
  import pal_array_pkg::*;
#(
  parameter int N_IN = 4,
  parameter int N_MC = 4,
  parameter int N_PT = 3
) (
  input  logic [N_MC*N_PT*LIT_PAIR*(N_IN+N_MC)-1:0] rows_flat,
  input  logic [((N_MC > 1) ? $clog2(N_MC) : 1)-1:0] wr_addr,
  input  logic [N_PT*LIT_PAIR*(N_IN+N_MC)-1:0]       new_row,
  output logic                                       loop_found
);
  localparam int N_SIG  = N_IN + N_MC;
  localparam int TERM_W = LIT_PAIR * N_SIG;
  localparam int ROW_W  = N_PT * TERM_W;

  logic [N_MC-1:0] dep [N_MC];
  logic            self_dep;

  always_comb begin
    logic [ROW_W-1:0] sel;
    self_dep = 1'b0;
    for (int i = 0; i < N_MC; i++) begin
      sel = (i == int'(wr_addr)) ? new_row : rows_flat[i*ROW_W +: ROW_W];
      for (int j = 0; j < N_MC; j++) begin
        dep[i][j] = 1'b0;
        for (int t = 0; t < N_PT; t++) begin
          dep[i][j] = dep[i][j]
                    | sel[t*TERM_W + LIT_PAIR*(N_IN+j) + LIT_TRUE]
                    | sel[t*TERM_W + LIT_PAIR*(N_IN+j) + LIT_COMP];
        end
      end
      if (i == int'(wr_addr) && dep[i][i]) self_dep = 1'b1;
    end
  end

  // Transitive closure by repeated extension of each reach set
  always_comb begin
    logic [N_MC-1:0] reach [N_MC];
    logic [N_MC-1:0] nxt   [N_MC];
    for (int i = 0; i < N_MC; i++) begin
      reach[i] = dep[i];
      nxt[i]   = dep[i];
    end
    for (int r = 1; r < N_MC; r++) begin
      for (int i = 0; i < N_MC; i++) begin
        nxt[i] = reach[i];
        for (int j = 0; j < N_MC; j++) begin
          if (reach[i][j]) nxt[i] = nxt[i] | dep[j];
        end
      end
      for (int i = 0; i < N_MC; i++) reach[i] = nxt[i];
    end
    loop_found = 1'b0;
    for (int i = 0; i < N_MC; i++) loop_found = loop_found | reach[i][i];
  end

  // R7: a direct self-reference is always reported as a loop
  always_comb begin
    if (self_dep) begin
      self_loop_chk: assert (loop_found);
    end
  end
endmodule

// File: rtl/pal_macro_array.sv
module pal_macro_array
  import pal_array_pkg::*;
#(
  parameter int N_IN = 4,
  parameter int N_MC = 4,
  parameter int N_PT = 3,
  localparam int N_SIG  = N_IN + N_MC,
  localparam int TERM_W = LIT_PAIR * N_SIG,
  localparam int ROW_W  = N_PT * TERM_W,
  localparam int CFG_W  = ROW_W + 1,
  localparam int AW     = (N_MC > 1) ? $clog2(N_MC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CFG_W-1:0] wr_data,
  input  logic [N_IN-1:0]  din,
  output logic [N_MC-1:0]  pal_out,
  output logic             config_error
);
  logic [CFG_W-1:0]         cfg_q [N_MC];
  logic [N_MC*ROW_W-1:0]    rows_flat;
  logic                     loop_found;
  logic [(N_MC+1)*N_MC-1:0] fb_flat;

  for (genvar k = 0; k < N_MC; k++) begin : g_flat
    assign rows_flat[k*ROW_W +: ROW_W] = cfg_q[k][ROW_W-1:0];
  end

  pal_loop_check #(.N_IN(N_IN), .N_MC(N_MC), .N_PT(N_PT)) u_loop (
    .rows_flat  (rows_flat),
    .wr_addr    (wr_addr),
    .new_row    (wr_data[ROW_W-1:0]),
    .loop_found (loop_found)
  );

  // Unrolled feedback: stage s sees stage s-1 results; N_MC stages cover
  // the longest acyclic chain, so the combinational path has no loop.
  assign fb_flat[N_MC-1:0] = '0;

  for (genvar s = 0; s < N_MC; s++) begin : g_stage
    logic [N_SIG-1:0] sig;
    assign sig = {fb_flat[s*N_MC +: N_MC], din};
    for (genvar k = 0; k < N_MC; k++) begin : g_cell
      pal_macrocell #(.N_SIG(N_SIG), .N_PT(N_PT)) u_cell (
        .row    (cfg_q[k][ROW_W-1:0]),
        .pol    (cfg_q[k][ROW_W]),
        .sig    (sig),
        .mc_out (fb_flat[(s+1)*N_MC + k])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_MC; k++) cfg_q[k] <= '0;
      pal_out      <= '0;
      config_error <= 1'b0;
    end else begin
      pal_out <= fb_flat[N_MC*N_MC +: N_MC];
      if (wr_en) begin
        if (loop_found) begin
          config_error <= 1'b1;
        end else begin
          cfg_q[wr_addr] <= wr_data;
          config_error   <= 1'b0;
        end
      end
    end
  end

  // R2
  accept_store_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !loop_found) |=> (cfg_q[$past(wr_addr)] == $past(wr_data)));

  // R7
  reject_keeps_row_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && loop_found) |=> (cfg_q[$past(wr_addr)] == $past(cfg_q[wr_addr])));

  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && loop_found) |=> config_error);

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(config_error));
endmodule

// File: tb/pal_macro_array_tb.sv
module pal_macro_array_tb;
  localparam int N_IN   = 4;
  localparam int N_MC   = 4;
  localparam int N_PT   = 3;
  localparam int N_SIG  = N_IN + N_MC;
  localparam int TERM_W = 2 * N_SIG;
  localparam int ROW_W  = N_PT * TERM_W;
  localparam int CFG_W  = ROW_W + 1;
  localparam int AW     = $clog2(N_MC);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [AW-1:0]    wr_addr = '0;
  logic [CFG_W-1:0] wr_data = '0;
  logic [N_IN-1:0]  din = '0;
  logic [N_MC-1:0]  pal_out;
  logic             config_error;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  logic [CFG_W-1:0] mcfg [N_MC];
  logic [N_MC-1:0]  exp_out = '0;
  logic             exp_err = 1'b0;

  always #10 clk = ~clk;

  pal_macro_array #(.N_IN(N_IN), .N_MC(N_MC), .N_PT(N_PT)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .din(din), .pal_out(pal_out),
    .config_error(config_error)
  );

  // Literal enable: term t, signal s, comp=1 for the complemented form
  function automatic logic [CFG_W-1:0] lit(int t, int s, bit comp);
    logic [CFG_W-1:0] w = '0;
    w[t*TERM_W + 2*s + (comp ? 1 : 0)] = 1'b1;
    return w;
  endfunction

  function automatic logic [CFG_W-1:0] pol_bit();
    logic [CFG_W-1:0] w = '0;
    w[ROW_W] = 1'b1;
    return w;
  endfunction

  function automatic bit uses(logic [CFG_W-1:0] w, int j);
    bit u = 0;
    for (int t = 0; t < N_PT; t++)
      if (w[t*TERM_W + 2*(N_IN+j)] || w[t*TERM_W + 2*(N_IN+j) + 1]) u = 1;
    return u;
  endfunction

  // Resolve cells in dependency order
  function automatic logic [N_MC-1:0] model_eval(logic [N_IN-1:0] d);
    logic [N_MC-1:0] val = '0;
    logic [N_MC-1:0] done = '0;
    for (int pass = 0; pass < N_MC; pass++) begin
      for (int k = 0; k < N_MC; k++) begin
        if (!done[k]) begin
          bit ready = 1;
          for (int j = 0; j < N_MC; j++)
            if (uses(mcfg[k], j) && !done[j]) ready = 0;
          if (ready) begin
            bit orv = 0;
            for (int t = 0; t < N_PT; t++) begin
              bit any = 0;
              bit prod = 1;
              for (int s = 0; s < N_SIG; s++) begin
                bit sv = (s < N_IN) ? d[s] : val[s-N_IN];
                bit tb = mcfg[k][t*TERM_W + 2*s];
                bit cb = mcfg[k][t*TERM_W + 2*s + 1];
                if (tb || cb) any = 1;
                if (tb && !sv) prod = 0;
                if (cb && sv) prod = 0;
              end
              if (any && prod) orv = 1;
            end
            val[k] = orv ^ mcfg[k][ROW_W];
            done[k] = 1'b1;
          end
        end
      end
    end
    return val;
  endfunction

  // Floyd-Warshall closure on the graph with cell a replaced by w
  function automatic bit model_loop(int a, logic [CFG_W-1:0] w);
    bit r [N_MC][N_MC];
    bit cyc = 0;
    for (int i = 0; i < N_MC; i++)
      for (int j = 0; j < N_MC; j++)
        r[i][j] = uses((i == a) ? w : mcfg[i], j);
    for (int k = 0; k < N_MC; k++)
      for (int i = 0; i < N_MC; i++)
        for (int j = 0; j < N_MC; j++)
          if (r[i][k] && r[k][j]) r[i][j] = 1;
    for (int i = 0; i < N_MC; i++) if (r[i][i]) cyc = 1;
    return cyc;
  endfunction

  task automatic step(bit r, bit we, int a, logic [CFG_W-1:0] w,
                      logic [N_IN-1:0] d, string req);
    @(negedge clk);
    rst = r; wr_en = we; wr_addr = AW'(a); wr_data = w; din = d;
    if (r) begin
      for (int k = 0; k < N_MC; k++) mcfg[k] = '0;
      exp_out = '0;
      exp_err = 1'b0;
    end else begin
      exp_out = model_eval(d);
      if (we) begin
        if (model_loop(a, w)) exp_err = 1'b1;
        else begin
          mcfg[a] = w;
          exp_err = 1'b0;
        end
      end
    end
    @(posedge clk);
    #5;
    vectors++;
    if (pal_out !== exp_out || config_error !== exp_err) begin
      miscompares++;
      $display("FAIL %s: pal_out=%b err=%b expected pal_out=%b err=%b",
               req, pal_out, config_error, exp_out, exp_err);
    end
  endtask

  function automatic bit target_f(logic [3:0] v);
    bit a = v[3], b = v[2], c = v[1], dd = v[0];
    return (!a && !c) || (!a && b) || (b && !c && !dd) || (a && !b && c && !dd);
  endfunction

  initial begin : watchdog
    #(20 * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : main
    logic [CFG_W-1:0] w_mc1, w_mc0, w_mc2, w_mc3;
    for (int k = 0; k < N_MC; k++) mcfg[k] = '0;
    // din[3]=A din[2]=B din[1]=C din[0]=D; cell j is signal 4+j
    w_mc1 = lit(0,3,1) | lit(0,1,1)
          | lit(1,3,1) | lit(1,2,0)
          | lit(2,2,0) | lit(2,1,1) | lit(2,0,1);
    w_mc0 = lit(0,5,0)
          | lit(1,3,0) | lit(1,2,1) | lit(1,1,0) | lit(1,0,1);
    w_mc2 = lit(0,1,0) | lit(0,0,0) | lit(1,4,0) | pol_bit();
    w_mc3 = lit(0,0,0) | lit(0,0,1) | lit(1,3,0);

    // R1: reset state
    repeat (3) step(1, 0, 0, '0, 4'hF, "R1");
    step(0, 0, 0, '0, 4'hA, "R1");
    // R3: empty cell with polarity only -> constant 1 from cell 3
    step(0, 1, 3, pol_bit(), 4'h0, "R3");
    step(0, 0, 0, '0, 4'h5, "R3");
    // R2: load the split function, chained polarity cell, contradictory term
    step(0, 1, 1, w_mc1, 4'h0, "R2");
    step(0, 1, 0, w_mc0, 4'h1, "R2");
    step(0, 1, 2, w_mc2, 4'h2, "R4");
    step(0, 1, 3, w_mc3, 4'h3, "R3");
    // R5 / R6: sweep all input combinations through the feedback chain
    for (int v = 0; v < 16; v++) begin
      step(0, 0, 0, '0, 4'(v), "R5");
      vectors++;
      if (pal_out[0] !== target_f(4'(v))) begin
        miscompares++;
        $display("FAIL R5: din=%h pal_out[0]=%b expected %b", v, pal_out[0], target_f(4'(v)));
      end
    end
    // R7: two-cell loop (cell1 uses cell0, cell0 uses cell1)
    step(0, 1, 1, w_mc1 | lit(2,4,0), 4'h6, "R7");
    step(0, 0, 0, '0, 4'h6, "R8");
    step(0, 0, 0, '0, 4'hB, "R7");
    // R7: direct self-reference on cell 3
    step(0, 1, 3, lit(0,7,0), 4'hC, "R7");
    step(0, 0, 0, '0, 4'hC, "R7");
    // R8: accepted write clears the flag
    step(0, 1, 3, lit(0,3,0) | lit(0,2,0), 4'hE, "R8");
    step(0, 0, 0, '0, 4'hC, "R8");
    // R7: three-cell loop cell1 -> cell2 -> cell0 -> cell1
    step(0, 1, 1, w_mc1 | lit(2,6,0), 4'h4, "R7");
    step(0, 0, 0, '0, 4'h9, "R7");
    // R7: self-reference on cell 0 while the flag is already set
    step(0, 1, 0, lit(0,4,1), 4'h9, "R7");
    // R8: legal rewrite of cell 0 with polarity, then re-sweep
    step(0, 1, 0, lit(0,5,0) | pol_bit(), 4'h0, "R8");
    for (int v = 0; v < 16; v++) step(0, 0, 0, '0, 4'(v), "R4");
    // R1: reset clears everything again
    step(1, 0, 0, '0, 4'h7, "R1");
    step(0, 0, 0, '0, 4'h7, "R1");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule